// File: doc/BRIEF.md
# Synthesizer Loop Divider and Phase Detector Core

This block holds the digital half of a phase-locked frequency synthesizer. A programmable feedback divider counts strobes of the already prescaled oscillator. A reference divider counts strobes of the crystal. Both run on one fast system clock. Each divider emits a one-cycle event at its terminal count. A phase/frequency detector turns the relative timing of the two events into pump-up and pump-down pulses for an external charge pump.

A lock monitor measures the width of every pump pulse against a programmable window. It raises a flag once the loop has settled. A test port can present either the reference event train or a square wave at half the feedback event rate. This lets the divider chain be checked without the analog loop.

The 15-bit divide word multiplies the fixed divide-by-eight prescaler outside the block. With a 4 MHz crystal, the three reference ratios give comparison rates of 7.8125 kHz (ratio 512), 6.25 kHz (ratio 640) and 3.90625 kHz (ratio 1024).

Top module: `pllsyn_core`

## Requirements
- R1: With `vco_ce` high every cycle and test mode selecting the feedback view, `test_out` changes level once every N cycles, where N is the value of `div_word`.
- R2: A new `div_word` value written partway through a feedback count takes effect only after the current count ends. The interval in progress keeps the old length and the next interval has the new length.
- R3: `ref_sel` picks the reference ratio: code 2'b00 gives 512 crystal strobes per event, 2'b01 gives 640 and 2'b10 gives 1024.
- R4: The spare code 2'b11 of `ref_sel` behaves as ratio 1024.
- R5: A reference event sets `pump_up` and a feedback event sets `pump_dn`. Once both are high they stay high together for exactly one cycle and are then released. With the feedback event lagging by d cycles, `pump_up` is high for d+1 cycles and `pump_dn` for one cycle.
- R6: `locked` rises only after 4 consecutive comparisons in which the run of cycles with either pump output high was shorter than `lock_win`.
- R7: A pump run that reaches `lock_win` cycles clears `locked` by the following cycle and restarts the count of good comparisons.
- R8: With test mode selecting the reference view, `test_out` is a one-cycle pulse per reference event.
- R9: With test mode selecting the feedback view, `test_out` toggles on each feedback event, so its period is twice the feedback event period.
- R10: While `test_en` is low, `test_out` is held low.
- R11: During reset, `pump_up`, `pump_dn`, `locked` and `test_out` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than both strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| vco_ce | input | 1 | One-cycle strobe per prescaled oscillator edge |
| xtal_ce | input | 1 | One-cycle strobe per crystal edge |
| div_word | input | 15 | Feedback division ratio N |
| ref_sel | input | 2 | Reference ratio code (00=512, 01=640, 10/11=1024) |
| lock_win | input | 6 | Pump pulse width limit in clock cycles |
| test_en | input | 1 | Enables the test port |
| test_sel | input | 1 | Test view: 0 reference events, 1 half-rate feedback |
| pump_up | output | 1 | Charge pump up request |
| pump_dn | output | 1 | Charge pump down request |
| locked | output | 1 | Loop settled flag |
| test_out | output | 1 | Test port output |

## Verification
The two detector outputs can be set in the same cycle. This happens when the reference and feedback events coincide, and the lock monitor must then treat the brief overlap as one short pulse. The bench aligns both dividers from reset for this case. It then withholds a few oscillator or crystal strobes to move one edge against the other by a known number of cycles. It checks that the pump run lengths are d+1 and 1, and that the lock flag stays, drops or returns as a bench model of the run lengths predicts.

// File: rtl/pllsyn_pkg.sv
package pllsyn_pkg;

   typedef enum logic [1:0] {
      REF_RATIO_A   = 2'b00,
      REF_RATIO_B   = 2'b01,
      REF_RATIO_C   = 2'b10,
      REF_RATIO_RSV = 2'b11
   } ref_sel_e;

   typedef enum logic {
      TVIEW_REF = 1'b0,
      TVIEW_FB  = 1'b1
   } test_view_e;

endpackage

// File: rtl/pllsyn_fb_div.sv
module pllsyn_fb_div #(
   parameter int DIV_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic [DIV_W-1:0] ratio,
   output logic             evt
);

   logic [DIV_W-1:0] cnt_q;
   logic             term;

   if (DIV_W < 2) begin : g_chk_w
      $error("pllsyn_fb_div: DIV_W too small");
   end

   assign term = ce && (cnt_q == '0);

   // ratio is sampled only on the terminal count, so a rewrite never shortens a period
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         evt   <= 1'b0;
      end else begin
         evt <= term;
         if (ce) begin
            cnt_q <= term ? (ratio - 1'b1) : (cnt_q - 1'b1);
         end
      end
   end

endmodule

// File: rtl/pllsyn_ref_div.sv
module pllsyn_ref_div
   import pllsyn_pkg::*;
#(
   parameter int RATIO_A = 512,
   parameter int RATIO_B = 640,
   parameter int RATIO_C = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce,
   input  logic [1:0] sel,
   output logic       evt
);

   localparam int RMAX_AB = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
   localparam int RMAX    = (RMAX_AB > RATIO_C) ? RMAX_AB : RATIO_C;
   localparam int CNT_W   = $clog2(RMAX);

   if (RATIO_A < 2 || RATIO_B < 2 || RATIO_C < 2) begin : g_chk_r
      $error("pllsyn_ref_div: ratios must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;
   logic             term;

   always_comb begin
      unique case (ref_sel_e'(sel))
         REF_RATIO_A: reload = CNT_W'(RATIO_A - 1);
         REF_RATIO_B: reload = CNT_W'(RATIO_B - 1);
         default:     reload = CNT_W'(RATIO_C - 1);
      endcase
   end

   assign term = ce && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         evt   <= 1'b0;
      end else begin
         evt <= term;
         if (ce) begin
            cnt_q <= term ? reload : (cnt_q - 1'b1);
         end
      end
   end

endmodule

// File: rtl/pllsyn_pfd.sv
module pllsyn_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_evt,
   input  logic fb_evt,
   output logic up,
   output logic dn
);

   // both outputs are held together for one cycle before release: no dead zone
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up <= 1'b0;
         dn <= 1'b0;
      end else if (up && dn) begin
         up <= ref_evt;
         dn <= fb_evt;
      end else begin
         up <= up | ref_evt;
         dn <= dn | fb_evt;
      end
   end

endmodule

// File: rtl/pllsyn_lock_det.sv
module pllsyn_lock_det #(
   parameter int WIN_W    = 6,
   parameter int LOCK_CNT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up,
   input  logic             dn,
   input  logic [WIN_W-1:0] win,
   output logic             locked
);

   localparam int CW = WIN_W + 1;
   localparam int GW = $clog2(LOCK_CNT + 1);

   if (WIN_W < 1 || LOCK_CNT < 1) begin : g_chk_p
      $error("pllsyn_lock_det: bad parameters");
   end

   logic [CW-1:0] run_q, run_n;
   logic [GW-1:0] good_q, good_n;
   logic          bad_q;
   logic          active;

   assign active = up | dn;
   assign run_n  = (&run_q) ? run_q : run_q + 1'b1;
   assign good_n = (good_q == GW'(LOCK_CNT)) ? good_q : good_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         good_q <= '0;
         bad_q  <= 1'b0;
         locked <= 1'b0;
      end else if (active) begin
         run_q <= run_n;
         if (run_n >= {1'b0, win}) begin
            bad_q  <= 1'b1;
            good_q <= '0;
            locked <= 1'b0;
         end
      end else if (run_q != '0) begin
         // first idle cycle after a pulse closes one comparison
         run_q <= '0;
         bad_q <= 1'b0;
         if (!bad_q) begin
            good_q <= good_n;
            if (good_n == GW'(LOCK_CNT)) begin
               locked <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pllsyn_core.sv
module pllsyn_core #(
   parameter int DIV_W     = 15,
   parameter int WIN_W     = 6,
   parameter int LOCK_CNT  = 4,
   parameter int RATIO_A   = 512,
   parameter int RATIO_B   = 640,
   parameter int RATIO_C   = 1024,
   parameter bit TEST_PORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vco_ce,
   input  logic             xtal_ce,
   input  logic [DIV_W-1:0] div_word,
   input  logic [1:0]       ref_sel,
   input  logic [WIN_W-1:0] lock_win,
   input  logic             test_en,
   input  logic             test_sel,
   output logic             pump_up,
   output logic             pump_dn,
   output logic             locked,
   output logic             test_out
);

   logic fb_evt;
   logic ref_evt;

   pllsyn_fb_div #(.DIV_W(DIV_W)) u_fb_div (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (vco_ce),
      .ratio (div_word),
      .evt   (fb_evt)
   );

   pllsyn_ref_div #(
      .RATIO_A (RATIO_A),
      .RATIO_B (RATIO_B),
      .RATIO_C (RATIO_C)
   ) u_ref_div (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (xtal_ce),
      .sel   (ref_sel),
      .evt   (ref_evt)
   );

   pllsyn_pfd u_pfd (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_evt (ref_evt),
      .fb_evt  (fb_evt),
      .up      (pump_up),
      .dn      (pump_dn)
   );

   pllsyn_lock_det #(
      .WIN_W    (WIN_W),
      .LOCK_CNT (LOCK_CNT)
   ) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .up     (pump_up),
      .dn     (pump_dn),
      .win    (lock_win),
      .locked (locked)
   );

   if (TEST_PORT) begin : g_test
      logic fb_half_q;
      logic test_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fb_half_q <= 1'b0;
            test_q    <= 1'b0;
         end else begin
            fb_half_q <= fb_half_q ^ fb_evt;
            if (!test_en) begin
               test_q <= 1'b0;
            end else if (pllsyn_pkg::test_view_e'(test_sel) == pllsyn_pkg::TVIEW_FB) begin
               test_q <= fb_half_q;
            end else begin
               test_q <= ref_evt;
            end
         end
      end
      assign test_out = test_q;
   end else begin : g_no_test
      assign test_out = 1'b0;
   end

endmodule

// File: rtl/pllsyn_core_chk.sv
module pllsyn_core_chk #(
   parameter int WIN_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pump_up,
   input logic             pump_dn,
   input logic             locked,
   input logic             test_out,
   input logic             test_en,
   input logic             test_sel,
   input logic [WIN_W-1:0] lock_win
);

   logic [WIN_W:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (pump_up || pump_dn) begin
         run_q <= (&run_q) ? run_q : run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   assert_pfd_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pump_up && pump_dn) |=> !(pump_up && pump_dn));

   assert_lock_after_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(!(pump_up || pump_dn)));

   assert_long_pulse_unlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q != '0 && run_q >= {1'b0, lock_win}) |-> !locked);

   assert_ref_view_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (test_out && test_en && !test_sel && $past(test_en && !test_sel)) |=> !test_out);

   assert_test_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!test_en) |-> !test_out);

endmodule

bind pllsyn_core pllsyn_core_chk #(.WIN_W(WIN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pump_up  (pump_up),
   .pump_dn  (pump_dn),
   .locked   (locked),
   .test_out (test_out),
   .test_en  (test_en),
   .test_sel (test_sel),
   .lock_win (lock_win)
);

// File: tb/pllsyn_core_test.sv
module pllsyn_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vco_ce = 1'b0;
   logic        xtal_ce = 1'b0;
   logic [14:0] div_word = 15'd512;
   logic [1:0]  ref_sel = 2'b00;
   logic [5:0]  lock_win = 6'd8;
   logic        test_en = 1'b0;
   logic        test_sel = 1'b0;
   logic        pump_up, pump_dn, locked, test_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pllsyn_core uut (
      .clk(clk), .rst_n(rst_n), .vco_ce(vco_ce), .xtal_ce(xtal_ce),
      .div_word(div_word), .ref_sel(ref_sel), .lock_win(lock_win),
      .test_en(test_en), .test_sel(test_sel),
      .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked), .test_out(test_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_ratio(input logic [1:0] s);
      case (s)
         2'b00:   return 512;
         2'b01:   return 640;
         default: return 1024;
      endcase
   endfunction

   // monitor state: period measurement and lock model
   int    meas_mode = 0;       // 0 none, 1 reference view, 2 feedback view
   int    exp_period = 0;
   int    exp_next = 0;
   int    skip_ev = 0;
   string per_req = "R3";
   int    ce_cnt = 0;
   int    hi_run = 0;
   logic  prev_to = 1'b0;
   logic  prev_te = 1'b0;
   int    m_run = 0;
   int    m_idle = 0;
   int    m_good = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         // lock model from observed pump activity
         if (pump_up || pump_dn) begin
            m_run++;
            m_idle = 0;
            if (m_run == int'(lock_win) + 1) chk("R7 lock cleared by long pulse", locked, 0);
         end else begin
            if (m_run > 0) begin
               if (m_run < int'(lock_win)) m_good = (m_good < 4) ? m_good + 1 : 4;
               else m_good = 0;
            end
            m_run = 0;
            m_idle++;
            if (m_idle == 3) chk("R6 lock after good comparisons", locked, (m_good >= 4) ? 1 : 0);
         end
         // test port idle
         if (!test_en && !prev_te) chk("R10 test port idle", test_out, 0);
         // period measurement
         if (meas_mode == 1) begin
            if (xtal_ce) ce_cnt++;
            if (test_out) hi_run++;
            if (!test_out && prev_to) begin
               chk("R8 reference pulse width", hi_run, 1);
               hi_run = 0;
            end
            if (test_out && !prev_to) begin
               if (skip_ev > 0) skip_ev--;
               else chk(per_req, ce_cnt, exp_period);
               ce_cnt = 0;
               exp_period = exp_next;
            end
         end else if (meas_mode == 2) begin
            if (vco_ce) ce_cnt++;
            if (test_out != prev_to) begin
               if (skip_ev > 0) skip_ev--;
               else chk(per_req, ce_cnt, exp_period);
               ce_cnt = 0;
               exp_period = exp_next;
            end
         end
      end
      prev_to = test_out;
      prev_te = test_en;
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic arm(input int mode, input int per, input string req);
      meas_mode  = mode;
      exp_period = per;
      exp_next   = per;
      skip_ev    = 2;
      ce_cnt     = 0;
      hi_run     = 0;
      per_req    = req;
   endtask

   task automatic measure_runs(input int exp_up, input int exp_dn);
      int up_n = 0;
      int dn_n = 0;
      int both_n = 0;
      @(negedge clk);
      while (!(pump_up || pump_dn)) @(negedge clk);
      while (pump_up || pump_dn) begin
         if (pump_up) up_n++;
         if (pump_dn) dn_n++;
         if (pump_up && pump_dn) both_n++;
         @(negedge clk);
      end
      chk("R5 up run length", up_n, exp_up);
      chk("R5 down run length", dn_n, exp_dn);
      chk("R5 overlap one cycle", both_n, 1);
   endtask

   // watchdog
   initial begin
      for (int i = 0; i < 100000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      // R11 reset state
      cyc(3);
      @(negedge clk);
      chk("R11 pump_up in reset", pump_up, 0);
      chk("R11 pump_dn in reset", pump_dn, 0);
      chk("R11 locked in reset", locked, 0);
      chk("R11 test_out in reset", test_out, 0);
      @(posedge clk); #1;
      vco_ce = 1'b1;
      xtal_ce = 1'b1;
      rst_n = 1'b1;

      // aligned loop: N=512 against ratio 512
      cyc(6 * 512 + 100);
      @(negedge clk);
      chk("R6 locked when aligned", locked, 1);

      // feedback lags by 3 cycles: short pulses, still locked
      @(posedge clk); #1;
      vco_ce = 1'b0;
      cyc(3);
      vco_ce = 1'b1;
      measure_runs(4, 1);
      @(negedge clk);
      chk("R6 small offset keeps lock", locked, 1);

      // feedback lags by 13 cycles: pulses exceed the window
      cyc(100);
      vco_ce = 1'b0;
      cyc(10);
      vco_ce = 1'b1;
      measure_runs(14, 1);
      cyc(2 * 512);
      @(negedge clk);
      chk("R7 lock lost on wide pulses", locked, 0);

      // hold back the reference by 13 to realign, then relock
      cyc(100);
      xtal_ce = 1'b0;
      cyc(13);
      xtal_ce = 1'b1;
      cyc(6 * 512);
      @(negedge clk);
      chk("R6 relock after realign", locked, 1);

      // reference view periods for every select code
      @(posedge clk); #1;
      test_en = 1'b1;
      test_sel = 1'b0;
      for (int s = 0; s < 4; s++) begin
         ref_sel = 2'(s);
         arm(1, exp_ratio(2'(s)), (s == 3) ? "R4 spare ratio code" : "R3 reference ratio");
         cyc(4 * exp_ratio(2'(s)) + 20);
      end

      // feedback view, then a mid-interval divide word rewrite
      @(posedge clk); #1;
      meas_mode = 0;
      ref_sel = 2'b00;
      test_sel = 1'b1;
      div_word = 15'd100;
      arm(2, 100, "R1 R9 feedback toggle interval");
      cyc(500);
      @(negedge clk);
      while (test_out == prev_to_snapshot(test_out)) @(negedge clk);
      @(posedge clk); #1;
      div_word = 15'd37;
      exp_next = 37;
      per_req = "R2 rewrite applies at terminal count";
      cyc(200);

      // random divide words
      for (int k = 0; k < 8; k++) begin
         int n;
         n = int'($urandom_range(300, 2));
         @(posedge clk); #1;
         div_word = 15'(n);
         arm(2, n, "R1 R9 feedback toggle interval");
         cyc(4 * n + 20);
      end

      // test port off
      @(posedge clk); #1;
      meas_mode = 0;
      test_en = 1'b0;
      cyc(50);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   // level of test_out seen at the previous sample, read by the sequence above
   logic last_to = 1'b0;
   always @(posedge clk) last_to <= test_out;
   function automatic logic prev_to_snapshot(input logic cur);
      return (cur == cur) ? last_to : 1'b0;
   endfunction

endmodule